// File: doc/BRIEF.md
# Dual-Channel Serial Controller Register Interface

This block is the byte-wide bus slave of a two-channel asynchronous serial controller. One address bit selects the channel and another selects the control port or the data port. A strap input can exchange the roles of these two bits. Each channel keeps a small bank of configuration registers that are reached indirectly. A control write with the channel's pointer at zero loads the pointer. The next control access then goes to the chosen register, and after that access the pointer returns to zero.

A reset field in a register shared by both channels can reset one channel or both. The reset lands at the clock edge after the write. Line settings are decoded onto output ports for each channel: parity, stop-bit field, character length, enables and a total clock divisor. A simple byte stream stands in for the serial line in each direction.

Reading the data port returns the waiting received byte and clears the receive-available flag. Writing the data port while transmit is enabled sends the byte at once and reports the transmitter empty and all sent.

Top module: `dual_sio_regs`

## Requirements
- R1: With `addr_swap` low, address bit 0 selects data (1) or control (0) and bit 1 selects channel B (1) or A (0). With `addr_swap` high the two bits exchange roles. Channel A is index 0 of every per-channel port and channel B is index 1.
- R2: A control write while the pointer is 0 loads the pointer from bits 2:0. If bits 5:3 hold 001, 8 is added to the pointer. The next control read or write goes to the pointed register, and the pointer is 0 again after that access.
- R3: Control reads return: register 0 status (bit 0 receive available, bit 2 transmit empty, bit 6 fixed 1), register 1 special status (bits 2:1 fixed 11, bit 0 all sent), register 4 mode, register 12 divisor low, register 13 divisor high. Every other register number reads 0. Writes to register numbers other than 3, 4, 5, 9, 12 and 13 change nothing.
- R4: A write to register 9 acts on bits 7:6: 01 resets channel B, 10 resets channel A, 11 resets both, and 00 does nothing. The reset takes effect at the clock edge after the edge that took the write.
- R5: After a channel reset or the hardware reset, that channel has mode 0x04, registers 3, 5, 12 and 13 at 0, status 0x44, special status 0x07 and pointer 0. The other channel is untouched by a single-channel reset.
- R6: Mode register bit 0 drives `par_en`, bit 1 drives `par_even`, and bits 3:2 drive `stop_sel` (01 one, 10 one and a half, 11 two stop bits).
- R7: Register 5 bit 3 drives `tx_en` and bits 6:5 set `char_len` (00→5, 01→7, 10→6, 11→8). Register 3 bit 0 drives `rx_en`.
- R8: `clk_div` equals ({reg13, reg12} + 2) times the multiplier set by mode bits 7:6 (00 x1, 01 x16, 10 x32, 11 x64).
- R9: An incoming byte is accepted only while receive is enabled and no byte is waiting; `rx_ready` shows exactly that condition. An accepted byte sets status bit 0, and a byte offered otherwise is dropped.
- R10: A data read returns the waiting byte and clears status bit 0. If a byte is accepted in the same cycle as a data read, the read returns the older buffer content and the flag stays set for the new byte.
- R11: A data write with transmit enabled gives a one-cycle `tx_valid` pulse carrying the byte in the next cycle, and sets status bit 2 and special bit 0. With transmit disabled the write gives no pulse and clears both bits.
- R12: In the cycle whose closing edge applies a channel reset, a bus access to that channel and a byte offered to it are lost, and the channel ends in its reset state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_swap | input | 1 | Exchange channel and register-select address bits |
| bus_cs | input | 1 | Bus access this cycle |
| bus_we | input | 1 | 1 write, 0 read |
| bus_addr | input | 2 | Channel and control/data select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the access cycle |
| rx_push | input | 2 | Incoming byte offered, per channel |
| rx_byte | input | 2x8 | Incoming byte, per channel |
| rx_ready | output | 2 | Channel will accept a byte |
| tx_valid | output | 2 | Transmitted byte pulse |
| tx_data | output | 2x8 | Transmitted byte |
| par_en | output | 2 | Parity enabled |
| par_even | output | 2 | Even parity selected |
| stop_sel | output | 2x2 | Stop-bit field |
| char_len | output | 2x4 | Character length in bits |
| clk_div | output | 2x23 | Total clock divisor |
| tx_en | output | 2 | Transmit enabled |
| rx_en | output | 2 | Receive enabled |

## Verification
A pending channel reset can fall in the same cycle as a bus write to that channel's data port and a byte offered on its receive stream. The bench provokes this by issuing the transmit write and the byte on the cycle right after the reset code, with both directions enabled beforehand. It judges the outcome from the missing `tx_valid` pulse, a low `rx_ready` and a status read of 0x44. A second overlap, a data read in the same cycle as an accepted byte, is judged by the returned old byte and the flag still set afterwards.

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam int NCH   = 2;
  localparam int DW    = 8;
  localparam int TCW   = 2 * DW;
  localparam int REGW  = 4;
  localparam int MAXSH = 6;
  localparam int DIVW  = TCW + 1 + MAXSH;

  localparam logic [REGW-1:0] REG_STAT  = 4'd0;
  localparam logic [REGW-1:0] REG_SPEC  = 4'd1;
  localparam logic [REGW-1:0] REG_RXCTL = 4'd3;
  localparam logic [REGW-1:0] REG_MODE  = 4'd4;
  localparam logic [REGW-1:0] REG_TXCTL = 4'd5;
  localparam logic [REGW-1:0] REG_MRST  = 4'd9;
  localparam logic [REGW-1:0] REG_TCLO  = 4'd12;
  localparam logic [REGW-1:0] REG_TCHI  = 4'd13;

  localparam logic [2:0]    CMD_HIGH  = 3'd1;
  localparam logic [DW-1:0] MODE_RST  = 8'h04;
  localparam logic [DW-1:0] SPEC_BASE = 8'h06;

  typedef struct packed {
    logic            par_en;
    logic            par_even;
    logic [1:0]      stop_sel;
    logic [3:0]      char_len;
    logic [DIVW-1:0] clk_div;
    logic            tx_en;
    logic            rx_en;
  } line_cfg_t;

  function automatic logic [3:0] char_len_of(input logic [1:0] f);
    case (f)
      2'b00:   char_len_of = 4'd5;
      2'b01:   char_len_of = 4'd7;
      2'b10:   char_len_of = 4'd6;
      default: char_len_of = 4'd8;
    endcase
  endfunction

  function automatic logic [2:0] mult_shift(input logic [1:0] f);
    case (f)
      2'b00:   mult_shift = 3'd0;
      2'b01:   mult_shift = 3'd4;
      2'b10:   mult_shift = 3'd5;
      default: mult_shift = 3'd6;
    endcase
  endfunction
endpackage

// File: rtl/sio_addr_dec.sv
module sio_addr_dec (
  input  logic [1:0] addr,
  input  logic       swap,
  output logic       chan,
  output logic       is_data
);
  always_comb begin
    if (swap) begin
      is_data = addr[1];
      chan    = addr[0];
    end else begin
      is_data = addr[0];
      chan    = addr[1];
    end
  end
endmodule

// File: rtl/sio_line_dec.sv
module sio_line_dec
  import sio_pkg::*;
(
  input  logic [1:0]     par_bits,
  input  logic [1:0]     stop_bits,
  input  logic [1:0]     mult_bits,
  input  logic [1:0]     clen,
  input  logic           tx_on,
  input  logic           rx_on,
  input  logic [TCW-1:0] tc,
  output line_cfg_t      cfg
);
  logic [TCW:0] base;

  always_comb begin
    base         = {1'b0, tc} + (TCW+1)'(2);
    cfg.par_en   = par_bits[0];
    cfg.par_even = par_bits[1];
    cfg.stop_sel = stop_bits;
    cfg.char_len = char_len_of(clen);
    cfg.clk_div  = DIVW'(base) << mult_shift(mult_bits);
    cfg.tx_en    = tx_on;
    cfg.rx_en    = rx_on;
  end
endmodule

// File: rtl/sio_chan.sv
module sio_chan
  import sio_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_rst,
  input  logic          sel,
  input  logic          we,
  input  logic          is_data,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          mrst_wr,
  input  logic          rx_push,
  input  logic [DW-1:0] rx_byte,
  output logic          rx_ready,
  output logic          tx_valid,
  output logic [DW-1:0] tx_data,
  output line_cfg_t     cfg
);
  logic [REGW-1:0] ptr_q, ptr_d;
  logic            rxon_q, rxon_d;
  logic [DW-1:0]   mode_q, mode_d;
  logic            txon_q, txon_d;
  logic [1:0]      clen_q, clen_d;
  logic [DW-1:0]   tclo_q, tclo_d;
  logic [DW-1:0]   tchi_q, tchi_d;
  logic            rxav_q, rxav_d;
  logic            txe_q, txe_d;
  logic            sent_q, sent_d;
  logic            txv_q, txv_d;
  logic [DW-1:0]   rxbuf_q, txd_q;
  logic            rxbuf_en, txd_en;

  logic ctl_wr, ctl_rd, dat_wr, dat_rd, rx_take;

  always_comb begin
    ctl_wr   = sel & we & ~is_data;
    ctl_rd   = sel & ~we & ~is_data;
    dat_wr   = sel & we & is_data;
    dat_rd   = sel & ~we & is_data;
    rx_ready = rxon_q & ~rxav_q;
    rx_take  = rx_push & rx_ready;
    mrst_wr  = ctl_wr & (ptr_q == REG_MRST) & ~soft_rst;
    rxbuf_en = rx_take & ~soft_rst;
    txd_en   = dat_wr & txon_q & ~soft_rst;
  end

  always_comb begin
    ptr_d  = ptr_q;
    rxon_d = rxon_q;
    mode_d = mode_q;
    txon_d = txon_q;
    clen_d = clen_q;
    tclo_d = tclo_q;
    tchi_d = tchi_q;
    rxav_d = rxav_q;
    txe_d  = txe_q;
    sent_d = sent_q;
    txv_d  = 1'b0;
    if (soft_rst) begin
      ptr_d  = '0;
      rxon_d = 1'b0;
      mode_d = MODE_RST;
      txon_d = 1'b0;
      clen_d = 2'b00;
      tclo_d = '0;
      tchi_d = '0;
      rxav_d = 1'b0;
      txe_d  = 1'b1;
      sent_d = 1'b1;
    end else begin
      if (ctl_wr) begin
        if (ptr_q == REG_STAT) begin
          ptr_d = {(wdata[5:3] == CMD_HIGH), wdata[2:0]};
        end else begin
          ptr_d = '0;
          case (ptr_q)
            REG_RXCTL: rxon_d = wdata[0];
            REG_MODE:  mode_d = wdata;
            REG_TXCTL: begin
              txon_d = wdata[3];
              clen_d = wdata[6:5];
            end
            REG_TCLO:  tclo_d = wdata;
            REG_TCHI:  tchi_d = wdata;
            default:   ;
          endcase
        end
      end
      if (ctl_rd) ptr_d = '0;
      if (dat_wr) begin
        if (txon_q) begin
          txv_d  = 1'b1;
          txe_d  = 1'b1;
          sent_d = 1'b1;
        end else begin
          txe_d  = 1'b0;
          sent_d = 1'b0;
        end
      end
      if (dat_rd)  rxav_d = 1'b0;
      if (rx_take) rxav_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      rxon_q <= 1'b0;
      mode_q <= MODE_RST;
      txon_q <= 1'b0;
      clen_q <= 2'b00;
      tclo_q <= '0;
      tchi_q <= '0;
      rxav_q <= 1'b0;
      txe_q  <= 1'b1;
      sent_q <= 1'b1;
      txv_q  <= 1'b0;
    end else begin
      ptr_q  <= ptr_d;
      rxon_q <= rxon_d;
      mode_q <= mode_d;
      txon_q <= txon_d;
      clen_q <= clen_d;
      tclo_q <= tclo_d;
      tchi_q <= tchi_d;
      rxav_q <= rxav_d;
      txe_q  <= txe_d;
      sent_q <= sent_d;
      txv_q  <= txv_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxbuf_q <= '0;
      txd_q   <= '0;
    end else begin
      if (rxbuf_en) rxbuf_q <= rx_byte;
      if (txd_en)   txd_q   <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    if (is_data) begin
      rdata = rxbuf_q;
    end else begin
      case (ptr_q)
        REG_STAT: rdata = {1'b0, 1'b1, 3'b000, txe_q, 1'b0, rxav_q};
        REG_SPEC: rdata = SPEC_BASE | {7'b0, sent_q};
        REG_MODE: rdata = mode_q;
        REG_TCLO: rdata = tclo_q;
        REG_TCHI: rdata = tchi_q;
        default:  rdata = '0;
      endcase
    end
  end

  assign tx_valid = txv_q;
  assign tx_data  = txd_q;

  sio_line_dec u_line (
    .par_bits  (mode_q[1:0]),
    .stop_bits (mode_q[3:2]),
    .mult_bits (mode_q[7:6]),
    .clen      (clen_q),
    .tx_on     (txon_q),
    .rx_on     (rxon_q),
    .tc        ({tchi_q, tclo_q}),
    .cfg       (cfg)
  );
endmodule

// File: rtl/dual_sio_regs.sv
module dual_sio_regs
  import sio_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      addr_swap,
  input  logic                      bus_cs,
  input  logic                      bus_we,
  input  logic [1:0]                bus_addr,
  input  logic [DW-1:0]             bus_wdata,
  output logic [DW-1:0]             bus_rdata,
  input  logic [NCH-1:0]            rx_push,
  input  logic [NCH-1:0][DW-1:0]    rx_byte,
  output logic [NCH-1:0]            rx_ready,
  output logic [NCH-1:0]            tx_valid,
  output logic [NCH-1:0][DW-1:0]    tx_data,
  output logic [NCH-1:0]            par_en,
  output logic [NCH-1:0]            par_even,
  output logic [NCH-1:0][1:0]       stop_sel,
  output logic [NCH-1:0][3:0]       char_len,
  output logic [NCH-1:0][DIVW-1:0]  clk_div,
  output logic [NCH-1:0]            tx_en,
  output logic [NCH-1:0]            rx_en
);
  logic [1:0]             rst_sync_q;
  logic                   rst_n_i;
  logic                   chan_sel, is_data;
  logic [NCH-1:0]         mrst_wr;
  logic [NCH-1:0]         rst_pend_q, rst_pend_d;
  logic [NCH-1:0][DW-1:0] ch_rdata;
  line_cfg_t              cfg [NCH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  sio_addr_dec u_dec (
    .addr    (bus_addr),
    .swap    (addr_swap),
    .chan    (chan_sel),
    .is_data (is_data)
  );

  // Reset field: bit 7 -> channel A (index 0), bit 6 -> channel B (index 1)
  always_comb begin
    rst_pend_d[0] = (|mrst_wr) & bus_wdata[7];
    rst_pend_d[1] = (|mrst_wr) & bus_wdata[6];
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) rst_pend_q <= '0;
    else          rst_pend_q <= rst_pend_d;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    sio_chan u_chan (
      .clk      (clk),
      .rst_n    (rst_n_i),
      .soft_rst (rst_pend_q[c]),
      .sel      (bus_cs & (chan_sel == 1'(c))),
      .we       (bus_we),
      .is_data  (is_data),
      .wdata    (bus_wdata),
      .rdata    (ch_rdata[c]),
      .mrst_wr  (mrst_wr[c]),
      .rx_push  (rx_push[c]),
      .rx_byte  (rx_byte[c]),
      .rx_ready (rx_ready[c]),
      .tx_valid (tx_valid[c]),
      .tx_data  (tx_data[c]),
      .cfg      (cfg[c])
    );
    assign par_en[c]   = cfg[c].par_en;
    assign par_even[c] = cfg[c].par_even;
    assign stop_sel[c] = cfg[c].stop_sel;
    assign char_len[c] = cfg[c].char_len;
    assign clk_div[c]  = cfg[c].clk_div;
    assign tx_en[c]    = cfg[c].tx_en;
    assign rx_en[c]    = cfg[c].rx_en;
  end

  assign bus_rdata = (bus_cs & ~bus_we) ? ch_rdata[chan_sel] : '0;
endmodule

// File: rtl/sio_chk.sv
module sio_chk
  import sio_pkg::*;
(
  input logic                     clk,
  input logic                     rst_n,
  input logic                     addr_swap,
  input logic                     bus_cs,
  input logic                     bus_we,
  input logic [1:0]               bus_addr,
  input logic [NCH-1:0]           rx_push,
  input logic [NCH-1:0]           rx_ready,
  input logic [NCH-1:0]           tx_valid,
  input logic [NCH-1:0]           tx_en,
  input logic [NCH-1:0]           rst_pend,
  input logic [NCH-1:0][3:0]      char_len,
  input logic [NCH-1:0][DIVW-1:0] clk_div
);
  logic dat_bit, chan_bit;
  assign dat_bit  = addr_swap ? bus_addr[1] : bus_addr[0];
  assign chan_bit = addr_swap ? bus_addr[0] : bus_addr[1];

  for (genvar c = 0; c < NCH; c++) begin : g_c
    // R11
    tx_from_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid[c] |-> $past(bus_cs && bus_we && dat_bit && (chan_bit == 1'(c))));

    // R11
    tx_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid[c] |-> tx_en[c]);

    // R9
    rx_full_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_push[c] && rx_ready[c] && !rst_pend[c]) |=> !rx_ready[c]);

    // R4
    soft_reset_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_pend[c] |=> (char_len[c] == 4'd5 && clk_div[c] == DIVW'(2) && !tx_en[c] && !tx_valid[c]));
  end
endmodule

bind dual_sio_regs sio_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .addr_swap (addr_swap),
  .bus_cs    (bus_cs),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .rx_push   (rx_push),
  .rx_ready  (rx_ready),
  .tx_valid  (tx_valid),
  .tx_en     (tx_en),
  .rst_pend  (rst_pend_q),
  .char_len  (char_len),
  .clk_div   (clk_div)
);

// File: tb/sim_dual_sio_regs.sv
module sim_dual_sio_regs;
  import sio_pkg::*;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic addr_swap = 1'b0;
  logic bus_cs = 1'b0;
  logic bus_we = 1'b0;
  logic [1:0] bus_addr = 2'b00;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic [NCH-1:0] rx_push = '0;
  logic [NCH-1:0][7:0] rx_byte = '0;
  logic [NCH-1:0] rx_ready, tx_valid, par_en, par_even, tx_en, rx_en;
  logic [NCH-1:0][7:0] tx_data;
  logic [NCH-1:0][1:0] stop_sel;
  logic [NCH-1:0][3:0] char_len;
  logic [NCH-1:0][DIVW-1:0] clk_div;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_sio_regs u0 (
    .clk(clk), .rst_n(rst_n), .addr_swap(addr_swap), .bus_cs(bus_cs), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_push(rx_push), .rx_byte(rx_byte), .rx_ready(rx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .par_en(par_en), .par_even(par_even),
    .stop_sel(stop_sel), .char_len(char_len), .clk_div(clk_div), .tx_en(tx_en), .rx_en(rx_en)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] adr(input int ch, input bit dat);
    return addr_swap ? {dat, 1'(ch)} : {1'(ch), dat};
  endfunction

  function automatic logic [7:0] ptr_byte(input int r);
    return (r >= 8) ? (8'h08 | 8'(r & 7)) : 8'(r);
  endfunction

  task automatic idle();
    bus_cs = 1'b0; bus_we = 1'b0; rx_push = '0;
  endtask

  task automatic bwr(input logic [1:0] a, input logic [7:0] v);
    bus_cs = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = v;
    @(negedge clk); idle();
  endtask

  task automatic brd(input logic [1:0] a, output logic [7:0] v);
    bus_cs = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 v = bus_rdata;
    @(negedge clk); idle();
  endtask

  task automatic wreg(input int ch, input int r, input logic [7:0] v);
    bwr(adr(ch, 1'b0), ptr_byte(r));
    bwr(adr(ch, 1'b0), v);
  endtask

  task automatic rreg(input int ch, input int r, output logic [7:0] v);
    bwr(adr(ch, 1'b0), ptr_byte(r));
    brd(adr(ch, 1'b0), v);
  endtask

  task automatic push(input int ch, input logic [7:0] b);
    rx_push[ch] = 1'b1; rx_byte[ch] = b;
    @(negedge clk); idle();
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rreg(0, 0, v); check("R5 status after reset", v, 8'h44);
    rreg(0, 1, v); check("R5 special after reset", v, 8'h07);
    rreg(1, 4, v); check("R5 mode after reset", v, 8'h04);
    check("R7 char_len after reset", char_len[0], 4'd5);
    check("R8 clk_div after reset", clk_div[1], 2);
    check("R9 rx_ready after reset", rx_ready, 2'b00);
  endtask

  task automatic t_ptr();
    logic [7:0] v;
    wreg(1, 12, 8'h34);
    wreg(1, 13, 8'h12);
    rreg(1, 12, v); check("R2 high pointer read", v, 8'h34);
    brd(adr(1, 1'b0), v); check("R2 pointer back to 0", v, 8'h44);
    check("R8 divisor x1", clk_div[1], 32'h1236);
    check("R1 other channel untouched", clk_div[0], 2);
    wreg(1, 7, 8'hFF);
    rreg(1, 7, v); check("R3 unimplemented reads 0", v, 8'h00);
    check("R3 ignored write leaves outputs", {tx_en, rx_en}, 4'b0000);
  endtask

  task automatic t_mode();
    logic [7:0] v;
    wreg(1, 4, 8'hC7);
    check("R6 parity on", par_en[1], 1'b1);
    check("R6 even parity", par_even[1], 1'b1);
    check("R6 stop field", stop_sel[1], 2'b01);
    check("R8 divisor x64", clk_div[1], 32'h48D80);
    rreg(1, 4, v); check("R3 mode readback", v, 8'hC7);
    wreg(1, 4, 8'h4D);
    check("R6 odd parity", par_even[1], 1'b0);
    check("R6 two stop bits", stop_sel[1], 2'b11);
    check("R8 divisor x16", clk_div[1], 32'h12360);
  endtask

  task automatic t_txctl();
    wreg(1, 5, 8'h68);
    check("R7 8 bits", char_len[1], 4'd8);
    check("R7 tx enabled", tx_en[1], 1'b1);
    wreg(1, 5, 8'h20);
    check("R7 7 bits", char_len[1], 4'd7);
    check("R7 tx disabled", tx_en[1], 1'b0);
    wreg(1, 5, 8'h40);
    check("R7 6 bits", char_len[1], 4'd6);
  endtask

  task automatic t_rx();
    logic [7:0] v;
    wreg(0, 3, 8'h01);
    check("R7 rx enabled", rx_en[0], 1'b1);
    check("R9 ready when empty", rx_ready[0], 1'b1);
    push(0, 8'hA5);
    check("R9 not ready when full", rx_ready[0], 1'b0);
    rreg(0, 0, v); check("R9 status avail", v, 8'h45);
    push(0, 8'h5A);
    brd(adr(0, 1'b1), v); check("R10 data read keeps first byte", v, 8'hA5);
    rreg(0, 0, v); check("R10 flag cleared by read", v, 8'h44);
    bus_cs = 1'b1; bus_we = 1'b0; bus_addr = adr(0, 1'b1);
    rx_push[0] = 1'b1; rx_byte[0] = 8'hB7;
    #1 v = bus_rdata;
    @(negedge clk); idle();
    check("R10 same-cycle read returns old", v, 8'hA5);
    rreg(0, 0, v); check("R10 same-cycle flag stays set", v, 8'h45);
    brd(adr(0, 1'b1), v); check("R10 new byte read", v, 8'hB7);
    wreg(0, 3, 8'h00);
    push(0, 8'h99);
    rreg(0, 0, v); check("R9 disabled drops byte", v, 8'h44);
  endtask

  task automatic t_tx();
    logic [7:0] v;
    wreg(0, 5, 8'h08);
    bwr(adr(0, 1'b1), 8'h3C);
    check("R11 tx pulse", tx_valid[0], 1'b1);
    check("R11 tx byte", tx_data[0], 8'h3C);
    @(negedge clk);
    check("R11 pulse one cycle", tx_valid[0], 1'b0);
    wreg(0, 5, 8'h00);
    bwr(adr(0, 1'b1), 8'h55);
    check("R11 no pulse when disabled", tx_valid[0], 1'b0);
    rreg(0, 0, v); check("R11 tx empty cleared", v, 8'h40);
    rreg(0, 1, v); check("R11 all sent cleared", v, 8'h06);
    wreg(0, 5, 8'h08);
    bwr(adr(0, 1'b1), 8'h66);
    check("R11 resend byte", {7'b0, tx_valid[0], tx_data[0]}, 16'h0166);
    rreg(0, 0, v); check("R11 tx empty set", v, 8'h44);
    rreg(0, 1, v); check("R11 all sent set", v, 8'h07);
  endtask

  task automatic t_swap();
    logic [7:0] v;
    addr_swap = 1'b1;
    rreg(1, 12, v); check("R1 swapped channel B read", v, 8'h34);
    brd(2'b10, v); check("R1 swapped data of A", v, 8'hB7);
    addr_swap = 1'b0;
  endtask

  task automatic t_mrst();
    logic [7:0] v;
    wreg(0, 9, 8'h40);
    check("R4 not yet reset", clk_div[1], 32'h12360);
    @(negedge clk);
    check("R4 B reset divisor", clk_div[1], 2);
    check("R5 B char_len", char_len[1], 4'd5);
    check("R5 A untouched", tx_en[0], 1'b1);
    rreg(1, 4, v); check("R5 B mode", v, 8'h04);
    wreg(1, 9, 8'h00);
    @(negedge clk);
    check("R4 code 00 no reset", tx_en[0], 1'b1);
    wreg(1, 9, 8'hC0);
    @(negedge clk);
    check("R4 both reset", tx_en[0], 1'b0);
  endtask

  task automatic t_collide();
    logic [7:0] v;
    wreg(0, 3, 8'h01);
    wreg(0, 5, 8'h08);
    wreg(0, 9, 8'h80);
    bus_cs = 1'b1; bus_we = 1'b1; bus_addr = adr(0, 1'b1); bus_wdata = 8'h77;
    rx_push[0] = 1'b1; rx_byte[0] = 8'h11;
    @(negedge clk); idle();
    check("R12 write lost to reset", tx_valid[0], 1'b0);
    check("R12 rx not ready", rx_ready[0], 1'b0);
    rreg(0, 0, v); check("R12 byte lost to reset", v, 8'h44);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_ptr();
    t_mode();
    t_txctl();
    t_rx();
    t_tx();
    t_swap();
    t_mrst();
    t_collide();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule